// File: doc/BRIEF.md
# Interrupt Aggregation Controller with Selectable Register Layout

This block gathers up to sixteen interrupt source lines into one level-sensitive interrupt request for a parent controller. Each configured source has an enable bit and a sticky pending bit. A pending bit is set when its source line goes from low to high. Software clears a pending bit by writing a one to it. The request to the parent is raised while any source has both its pending bit and its enable bit set.

Software reaches the block over a plain 32-bit register port. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The port has no handshake, so every access completes in one cycle. A build-time parameter picks one of two layouts.

In the shared-word layout, one register at offset 0 holds the enables in its low half, and each pending bit sits 16 positions above its enable. In the separate layout, enables and pending bits live in two registers at parameterised offsets, and both use the low 16 bits. The source count and the lowest source position are also parameters. Source line `src_i[k]` feeds register position k, so only lines inside the configured window take part.

Top module: `irqagg_top`

## Requirements
- R1: In the shared-word layout (SPLIT=0), the register at byte offset 0 holds the enable for position k at bit k and the pending bit for position k at bit k+16. Bits 31:29 always read 0.
- R2: A pending bit is set on a low-to-high transition of its source line, whether or not that source is enabled. A line that stays high does not set the bit again after it has been cleared.
- R3: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged, so an enable update written with zeros in the pending field keeps pending events.
- R4: If a rising edge and a write-one-to-clear reach the same pending bit in the same cycle, the bit ends up set.
- R5: `irq_o` is a registered OR over all positions of (pending AND enable). It changes one clock after the pending or enable state changes, and it is low whenever no enabled source is pending.
- R6: Positions outside the window SRC_BASE to SRC_BASE+NUM_SRC-1 read as 0 in both enable and pending fields, ignore writes, and ignore their source lines.
- R7: In the separate layout (SPLIT=1), enables are at byte offset EN_OFS and pending bits are at ST_OFS, both in bits 15:0 with one bit per position. A write to the enable register leaves the pending bits alone.
- R8: After reset every enable bit, every pending bit and `irq_o` are 0. Clearing all pending bits and then writing all enables to 0 leaves `irq_o` low.
- R9: Reads from an offset with no register return 0, and writes to such an offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Interrupt source lines; line k maps to register position k |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request to the parent controller |

## Verification
The bench runs two instances side by side: a shared-word build with seven sources from position 0, and a separate-layout build with two sources at positions 5:4 and the two registers placed in reverse order.

Several stimulus patterns are used:
- An edge on a disabled source shows that latching does not depend on the enable.
- An enable write with zeros in the pending field shows that the pending bits survive it.
- A clear while the source line is still high tells edge capture apart from level capture.
- An all-ones write, together with a rising line outside the window, shows that unconfigured positions stay at zero.
- An edge and a clear landing in the same cycle check which of the two wins.
- The request line is sampled in the cycle right after each enable or pending change and again one cycle later, which pins down the single register stage on the output.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int SRC_LINES  = 16;
  localparam int STAT_SHIFT = 16;
  localparam int DATA_W     = 32;

  // Bit mask covering the configured source window.
  function automatic logic [SRC_LINES-1:0] window_mask(input int num, input int base);
    logic [SRC_LINES-1:0] m;
    m = '0;
    for (int k = 0; k < SRC_LINES; k++) begin
      if (k >= base && k < base + num) m[k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge
  import irqagg_pkg::*;
#(
  parameter logic [SRC_LINES-1:0] MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_LINES-1:0] src_i,
  output logic [SRC_LINES-1:0] rise_o
);
  logic [SRC_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i & MASK;
  end

  assign rise_o = src_i & ~prev_q & MASK;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter logic [SRC_LINES-1:0] MASK   = '1,
  parameter bit                   SPLIT  = 1'b0,
  parameter int                   ADDR_W = 4,
  parameter int                   EN_OFS = 0,
  parameter int                   ST_OFS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_LINES-1:0] rise_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [SRC_LINES-1:0] en_o,
  output logic [SRC_LINES-1:0] st_o
);
  logic [SRC_LINES-1:0] en_q, st_q;
  logic                 en_sel, st_sel;
  logic [SRC_LINES-1:0] clr_bits;

  generate
    if (SPLIT) begin : g_split
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
      localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:SRC_LINES];
      assign en_sel    = wr_i && (addr_i == EN_A);
      assign st_sel    = wr_i && (addr_i == ST_A);
      assign clr_bits  = wdata_i[SRC_LINES-1:0];
      always_comb begin
        if (addr_i == EN_A)      rdata_o = {{(DATA_W-SRC_LINES){1'b0}}, en_q};
        else if (addr_i == ST_A) rdata_o = {{(DATA_W-SRC_LINES){1'b0}}, st_q};
        else                     rdata_o = '0;
      end
    end else begin : g_shared
      localparam logic [DATA_W-1:0] RD_KEEP = 32'h1FFF_FFFF;
      logic hit;
      assign hit      = (addr_i == '0);
      assign en_sel   = wr_i && hit;
      assign st_sel   = wr_i && hit;
      assign clr_bits = wdata_i[DATA_W-1:STAT_SHIFT];
      assign rdata_o  = hit ? ({st_q, en_q} & RD_KEEP) : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_sel) en_q <= wdata_i[SRC_LINES-1:0] & MASK;
      // new edges take precedence over a clear in the same cycle
      st_q <= (st_q & ~(clr_bits & MASK & {SRC_LINES{st_sel}})) | rise_i;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;
endmodule

// File: rtl/irqagg_out.sv
module irqagg_out
  import irqagg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_LINES-1:0] en_i,
  input  logic [SRC_LINES-1:0] st_i,
  output logic                 irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(en_i & st_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int SRC_BASE = 0,
  parameter bit SPLIT    = 1'b0,
  parameter int ADDR_W   = 4,
  parameter int EN_OFS   = 0,
  parameter int ST_OFS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam logic [SRC_LINES-1:0] MASK = window_mask(NUM_SRC, SRC_BASE);

  logic [SRC_LINES-1:0] rise_w, en_w, st_w;

  irqagg_edge #(.MASK(MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise_w)
  );

  irqagg_regs #(
    .MASK(MASK), .SPLIT(SPLIT), .ADDR_W(ADDR_W), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .en_o(en_w), .st_o(st_w)
  );

  irqagg_out u_out (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .st_i(st_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter logic [SRC_LINES-1:0] MASK = '1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SRC_LINES-1:0] src_i,
  input logic [SRC_LINES-1:0] en_q,
  input logic [SRC_LINES-1:0] st_q,
  input logic                 irq_o
);
  logic [SRC_LINES-1:0] src_d;
  logic [SRC_LINES-1:0] rise_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_d <= '0;
    else        src_d <= src_i;
  end
  assign rise_c = src_i & ~src_d & MASK;

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & en_q)) |=> irq_o);  // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_q & en_q)) |=> !irq_o);  // R5
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c != '0) |=> ((st_q & $past(rise_c)) == $past(rise_c)));  // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(rise_c)) == '0));  // R2
  AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q) & ~MASK) == '0);  // R6
endmodule

bind irqagg_top irqagg_checker #(.MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .en_q(en_w), .st_q(st_w), .irq_o(irq_o)
);

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // instance A: shared word, 7 sources at 6:0
  logic [15:0] a_src = '0;
  logic        a_wr = 1'b0;
  logic [3:0]  a_addr = '0;
  logic [31:0] a_wdata = '0;
  logic [31:0] a_rdata;
  logic        a_irq;

  // instance B: separate layout, 2 sources at 5:4, enable at 4, pending at 0
  logic [15:0] b_src = '0;
  logic        b_wr = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic        b_irq;

  irqagg_top #(.NUM_SRC(7), .SRC_BASE(0), .SPLIT(1'b0)) u_irqagg_top (
    .clk(clk), .rst_n(rst_n), .src_i(a_src), .bus_wr(a_wr), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq_o(a_irq)
  );

  irqagg_top #(.NUM_SRC(2), .SRC_BASE(4), .SPLIT(1'b1), .EN_OFS(4), .ST_OFS(0)) u_irqagg_top_split (
    .clk(clk), .rst_n(rst_n), .src_i(b_src), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq_o(b_irq)
  );

  typedef struct {
    string       tag;
    logic [31:0] act;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  task automatic push(input string tag, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  // monitor: drains the scoreboard and compares
  always @(posedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic wr_a(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk); a_wr = 1'b1; a_addr = addr; a_wdata = data;
    @(negedge clk); a_wr = 1'b0; a_addr = '0; a_wdata = '0;
  endtask

  task automatic wr_b(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk); b_wr = 1'b1; b_addr = addr; b_wdata = data;
    @(negedge clk); b_wr = 1'b0; b_addr = '0; b_wdata = '0;
  endtask

  task automatic rd_a(input logic [3:0] addr, input logic [31:0] exp, input string tag);
    a_addr = addr; #1;
    push(tag, a_rdata, exp);
    a_addr = '0;
  endtask

  task automatic rd_b(input logic [3:0] addr, input logic [31:0] exp, input string tag);
    b_addr = addr; #1;
    push(tag, b_rdata, exp);
    b_addr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd_a(4'h0, 32'h0, "R8 reset word A");
    push("R8 reset irq A", {31'b0, a_irq}, 32'h0);
    rd_b(4'h0, 32'h0, "R8 reset pending B");
    rd_b(4'h4, 32'h0, "R8 reset enable B");

    // R8 init sequence
    wr_a(4'h0, 32'h1FFF_0000);
    wr_a(4'h0, 32'h0);
    @(negedge clk);
    push("R8 init irq A", {31'b0, a_irq}, 32'h0);

    // R2 edge on disabled source latches
    a_src[2] = 1'b1;
    @(negedge clk);
    rd_a(4'h0, 32'h0004_0000, "R2 latched while disabled");
    @(negedge clk);
    push("R5 disabled pending keeps irq low", {31'b0, a_irq}, 32'h0);

    // R3/R1 enable write with zero pending field keeps pending
    wr_a(4'h0, 32'h0000_0004);
    rd_a(4'h0, 32'h0004_0004, "R3 pending kept across enable write R1 layout");
    push("R5 irq not yet", {31'b0, a_irq}, 32'h0);
    @(negedge clk);
    push("R5 irq one cycle later", {31'b0, a_irq}, 32'h1);

    // R3 W1C while line still high; R2 no re-set on level
    wr_a(4'h0, 32'h0004_0004);
    rd_a(4'h0, 32'h0000_0004, "R3 W1C clears");
    push("R5 irq held one cycle", {31'b0, a_irq}, 32'h1);
    @(negedge clk);
    push("R5 irq drops", {31'b0, a_irq}, 32'h0);
    repeat (2) @(negedge clk);
    rd_a(4'h0, 32'h0000_0004, "R2 level does not re-set");

    // R6/R1 all-ones write
    wr_a(4'h0, 32'hFFFF_FFFF);
    rd_a(4'h0, 32'h0000_007F, "R6 out of range enables R1 top bits");
    wr_a(4'h0, 32'h0);

    // R4 set wins over same-cycle clear; R6 out-of-window line ignored
    @(negedge clk);
    a_src[1] = 1'b1; a_src[10] = 1'b1;
    a_wr = 1'b1; a_addr = 4'h0; a_wdata = 32'h0402_0000;
    @(negedge clk);
    a_wr = 1'b0; a_wdata = '0;
    rd_a(4'h0, 32'h0002_0000, "R4 set wins R6 line ignored");

    // R9 unmapped offset
    rd_a(4'h8, 32'h0, "R9 unmapped read");
    wr_a(4'h8, 32'hFFFF_FFFF);
    rd_a(4'h0, 32'h0002_0000, "R9 unmapped write no effect");

    // R8 clear all then disable all
    wr_a(4'h0, 32'h1FFF_0000);
    wr_a(4'h0, 32'h0);
    rd_a(4'h0, 32'h0, "R8 cleared word");
    @(negedge clk);
    push("R8 irq low after init", {31'b0, a_irq}, 32'h0);

    // separate layout R7
    b_src[5] = 1'b1; b_src[2] = 1'b1;
    @(negedge clk);
    rd_b(4'h0, 32'h0000_0020, "R7 pending at ST_OFS R6");
    rd_b(4'h4, 32'h0, "R7 enable still zero");
    wr_b(4'h4, 32'hFFFF_FFFF);
    rd_b(4'h4, 32'h0000_0030, "R7 enable window R6");
    rd_b(4'h0, 32'h0000_0020, "R7 enable write keeps pending");
    @(negedge clk);
    push("R7 irq B raised", {31'b0, b_irq}, 32'h1);
    wr_b(4'h0, 32'h0000_0010);
    rd_b(4'h0, 32'h0000_0020, "R3 B zero write keeps bit");
    wr_b(4'h0, 32'h0000_0020);
    rd_b(4'h0, 32'h0, "R3 B W1C");
    @(negedge clk);
    push("R5 irq B low", {31'b0, b_irq}, 32'h0);
    rd_b(4'hC, 32'h0, "R9 B unmapped read");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule